// File: doc/BRIEF.md
# AXI4-Lite Polling Run Sequencer

This block is a bus master that carries out one complete accelerator run over an AXI4-Lite link. A single-cycle `go` pulse launches it. It writes three 32-bit operands into the accelerator, writes 1 into the launch register, and then waits a fixed number of idle cycles before it first checks for completion. It then reads the completion register at a fixed cadence until bit 0 reads 1, and finally reads the result word. The number of completion reads is bounded. If that bound is used up, the run ends with a timeout flag instead of a result.

Every access targets `BASE_ADDR` plus a fixed offset. The launch register is at 0x00, completion at 0x04, the operands x, a and b at 0x08, 0x0C and 0x10, and the result at 0x14. The block has only one transaction in flight at a time.

All five AXI channels follow the valid/ready rules. The block holds a raised `awvalid`, `wvalid` or `arvalid` with stable address and data until the slave accepts it. It raises `bready` or `rready` only while it is waiting for that response. The slave may stall any channel for any number of cycles. The run simply stretches, and the fixed waits start counting only once a response has been received. The control and status pins carry no handshake: `res_valid` is a one-cycle pulse that cannot be stalled.

Top module: `lite_poll_seq`

## Requirements
- R1: An accepted run writes, in this order, `op_x` to BASE+0x08, `op_a` to BASE+0x0C, `op_b` to BASE+0x10 and the value 1 to BASE+0x00. The operands are those present on the cycle `go` is accepted, and every write uses `wstrb` all ones.
- R2: Only one transaction is outstanding at any time. The next address phase is raised only after the previous B or R handshake, and a write and a read are never active together.
- R3: A raised `awvalid`, `wvalid` or `arvalid` stays high, with its address or data unchanged, until the matching ready is seen.
- R4: After the B handshake of the launch write, exactly LATENCY idle cycles pass before `arvalid` rises for the first read of BASE+0x04.
- R5: After a completion read returns bit 0 equal to 0, exactly POLL_GAP idle cycles pass before the next completion read is raised.
- R6: When a completion read returns bit 0 equal to 1, BASE+0x14 is read in the very next cycle. `res_valid` then pulses for exactly one cycle with `res_data` equal to the returned word, and `done_val` reads 1.
- R7: If MAX_POLLS completion reads all return bit 0 equal to 0, the run ends with `err_timeout` set, `done_val` 0, no result read and no `res_valid`.
- R8: Any response other than OKAY (00) on B or R aborts the run at once. It sets `err_resp`, issues no further transaction and drops `busy`.
- R9: A `go` pulse while `busy` is high is ignored. An accepted `go` clears `err_timeout`, `err_resp` and `done_val`.
- R10: During and after reset, all valid and ready outputs, `busy`, `res_valid` and the error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Run launch pulse, accepted only when idle |
| op_x | input | 32 | Operand x, sampled with go |
| op_a | input | 32 | Operand a, sampled with go |
| op_b | input | 32 | Operand b, sampled with go |
| awaddr | output | ADDR_W | Write address |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Write byte strobes |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | ADDR_W | Read address |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 32 | Read data |
| rresp | input | 2 | Read response code |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| busy | output | 1 | Run in progress |
| res_valid | output | 1 | One-cycle pulse: result word available |
| res_data | output | 32 | Result word |
| done_val | output | 1 | Last completion bit read in this run |
| err_timeout | output | 1 | Completion never seen within MAX_POLLS reads |
| err_resp | output | 1 | Run aborted by a non-OKAY response |

## Verification
The assertions check the following on every cycle:
- the channel hold rules;
- the absence of overlapping write and read activity;
- that every read goes to the completion or result address;
- that `res_valid` is a single pulse and never coincides with an error;
- that a timeout happens only after exactly MAX_POLLS completion reads;
- that an aborted run leaves the bus quiet.

Several properties can only be shown by the bench's scenarios. These are the exact idle-cycle counts of the initial latency and the poll cadence, the ordering and content of the writes, and the returned result word. The same holds for the abort on a response error and for a `go` that is ignored while busy.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WX, S_WA, S_WB, S_WGO, S_WAIT, S_POLL, S_RES
  } lps_state_e;

  localparam logic [7:0] OFF_GO   = 8'h00;
  localparam logic [7:0] OFF_DONE = 8'h04;
  localparam logic [7:0] OFF_X    = 8'h08;
  localparam logic [7:0] OFF_A    = 8'h0C;
  localparam logic [7:0] OFF_B    = 8'h10;
  localparam logic [7:0] OFF_RES  = 8'h14;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/lps_wr_chan.sv
module lps_wr_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic [ADDR_W-1:0] awaddr,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic              fin,
  output logic              fin_ok
);
  logic b_wait;

  // Address and data phases retire independently; the response is
  // accepted only once both have been taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awvalid <= 1'b0;
      wvalid  <= 1'b0;
      b_wait  <= 1'b0;
      awaddr  <= '0;
      wdata   <= '0;
    end else if (req) begin
      awvalid <= 1'b1;
      wvalid  <= 1'b1;
      b_wait  <= 1'b1;
      awaddr  <= req_addr;
      wdata   <= req_data;
    end else begin
      if (awvalid && awready) awvalid <= 1'b0;
      if (wvalid && wready)   wvalid  <= 1'b0;
      if (fin)                b_wait  <= 1'b0;
    end
  end

  assign wstrb  = '1;
  assign bready = b_wait && !awvalid && !wvalid;
  assign fin    = bvalid && bready;
  assign fin_ok = (bresp == lps_pkg::RESP_OKAY);
endmodule

// File: rtl/lps_rd_chan.sv
module lps_rd_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] araddr,
  output logic              arvalid,
  input  logic              arready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rvalid,
  output logic              rready,
  output logic              fin,
  output logic              fin_ok,
  output logic [DATA_W-1:0] fin_data
);
  logic r_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arvalid <= 1'b0;
      r_wait  <= 1'b0;
      araddr  <= '0;
    end else if (req) begin
      arvalid <= 1'b1;
      r_wait  <= 1'b1;
      araddr  <= req_addr;
    end else begin
      if (arvalid && arready) arvalid <= 1'b0;
      if (fin)                r_wait  <= 1'b0;
    end
  end

  assign rready   = r_wait && !arvalid;
  assign fin      = rvalid && rready;
  assign fin_ok   = (rresp == lps_pkg::RESP_OKAY);
  assign fin_data = rdata;
endmodule

// File: rtl/lps_wait_cnt.sv
module lps_wait_cnt #(
  parameter int MAX_WAIT = 4,
  localparam int CW = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == 0);
endmodule

// File: rtl/lite_poll_seq.sv
module lite_poll_seq #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0000_0000,
  parameter int          LATENCY   = 4,
  parameter int          POLL_GAP  = 4,
  parameter int          MAX_POLLS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [31:0]       op_x,
  input  logic [31:0]       op_a,
  input  logic [31:0]       op_b,
  output logic [ADDR_W-1:0] awaddr,
  output logic              awvalid,
  input  logic              awready,
  output logic [31:0]       wdata,
  output logic [3:0]        wstrb,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic [ADDR_W-1:0] araddr,
  output logic              arvalid,
  input  logic              arready,
  input  logic [31:0]       rdata,
  input  logic [1:0]        rresp,
  input  logic              rvalid,
  output logic              rready,
  output logic              busy,
  output logic              res_valid,
  output logic [31:0]       res_data,
  output logic              done_val,
  output logic              err_timeout,
  output logic              err_resp
);
  import lps_pkg::*;

  localparam int MAX_WAIT = (LATENCY > POLL_GAP) ? LATENCY : POLL_GAP;
  localparam int CW       = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);
  localparam int PW       = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAT_LOAD = CW'(LATENCY - 1);
  localparam logic [CW-1:0] GAP_LOAD = CW'(POLL_GAP - 1);
  localparam logic [PW-1:0] POLL_LIM = PW'(MAX_POLLS);

  function automatic logic [ADDR_W-1:0] reg_addr(input logic [7:0] off);
    return ADDR_W'(BASE_ADDR) + ADDR_W'(off);
  endfunction

  lps_state_e state;
  logic [31:0] a_q, b_q;
  logic [PW-1:0] polls;

  logic              wr_req, wr_fin, wr_ok;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic              rd_req, rd_fin, rd_ok;
  logic [ADDR_W-1:0] rd_addr;
  logic [31:0]       rd_word;
  logic              cnt_load, cnt_zero;
  logic [CW-1:0]     cnt_val;

  lps_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(32)) wr_i (
    .clk(clk), .rst_n(rst_n), .req(wr_req), .req_addr(wr_addr), .req_data(wr_data),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .fin(wr_fin), .fin_ok(wr_ok)
  );

  lps_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(32)) rd_i (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .req_addr(rd_addr),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .fin(rd_fin), .fin_ok(rd_ok), .fin_data(rd_word)
  );

  lps_wait_cnt #(.MAX_WAIT(MAX_WAIT)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  // Transaction requests, issued on the same edge that retires the previous one
  always_comb begin
    wr_req   = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    rd_req   = 1'b0;
    rd_addr  = '0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state)
      S_IDLE: if (go) begin
        wr_req = 1'b1; wr_addr = reg_addr(OFF_X); wr_data = op_x;
      end
      S_WX: if (wr_fin && wr_ok) begin
        wr_req = 1'b1; wr_addr = reg_addr(OFF_A); wr_data = a_q;
      end
      S_WA: if (wr_fin && wr_ok) begin
        wr_req = 1'b1; wr_addr = reg_addr(OFF_B); wr_data = b_q;
      end
      S_WB: if (wr_fin && wr_ok) begin
        wr_req = 1'b1; wr_addr = reg_addr(OFF_GO); wr_data = 32'd1;
      end
      S_WGO: if (wr_fin && wr_ok) begin
        cnt_load = 1'b1; cnt_val = LAT_LOAD;
      end
      S_WAIT: if (cnt_zero) begin
        rd_req = 1'b1; rd_addr = reg_addr(OFF_DONE);
      end
      S_POLL: if (rd_fin && rd_ok) begin
        if (rd_word[0]) begin
          rd_req = 1'b1; rd_addr = reg_addr(OFF_RES);
        end else if (polls != POLL_LIM) begin
          cnt_load = 1'b1; cnt_val = GAP_LOAD;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      a_q         <= '0;
      b_q         <= '0;
      polls       <= '0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      done_val    <= 1'b0;
      err_timeout <= 1'b0;
      err_resp    <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (go) begin
          a_q         <= op_a;
          b_q         <= op_b;
          polls       <= '0;
          done_val    <= 1'b0;
          err_timeout <= 1'b0;
          err_resp    <= 1'b0;
          state       <= S_WX;
        end
        S_WX, S_WA, S_WB, S_WGO: if (wr_fin) begin
          if (!wr_ok) begin
            err_resp <= 1'b1;
            state    <= S_IDLE;
          end else begin
            unique case (state)
              S_WX:    state <= S_WA;
              S_WA:    state <= S_WB;
              S_WB:    state <= S_WGO;
              default: state <= S_WAIT;
            endcase
          end
        end
        S_WAIT: if (cnt_zero) begin
          polls <= polls + 1'b1;
          state <= S_POLL;
        end
        S_POLL: if (rd_fin) begin
          if (!rd_ok) begin
            err_resp <= 1'b1;
            state    <= S_IDLE;
          end else begin
            done_val <= rd_word[0];
            if (rd_word[0]) begin
              state <= S_RES;
            end else if (polls == POLL_LIM) begin
              err_timeout <= 1'b1;
              state       <= S_IDLE;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        S_RES: if (rd_fin) begin
          if (!rd_ok) begin
            err_resp <= 1'b1;
          end else begin
            res_data  <= rd_word;
            res_valid <= 1'b1;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0,
  parameter int          MAX_POLLS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              busy,
  input logic [ADDR_W-1:0] awaddr,
  input logic              awvalid,
  input logic              awready,
  input logic [31:0]       wdata,
  input logic              wvalid,
  input logic              wready,
  input logic              bready,
  input logic [ADDR_W-1:0] araddr,
  input logic              arvalid,
  input logic              arready,
  input logic              rready,
  input logic              res_valid,
  input logic              done_val,
  input logic              err_timeout,
  input logic              err_resp
);
  localparam logic [ADDR_W-1:0] A_DONE = ADDR_W'(BASE_ADDR) + ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(BASE_ADDR) + ADDR_W'(8'h14);

  int unsigned n_polls;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       n_polls <= 0;
    else if (go && !busy)                             n_polls <= 0;
    else if (arvalid && arready && araddr == A_DONE)  n_polls <= n_polls + 1;
  end

  p_aw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));
  p_w_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata));
  p_ar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid && $stable(araddr));
  p_one_txn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !((awvalid || wvalid || bready) && (arvalid || rready)));
  p_rd_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> (araddr == A_DONE || araddr == A_RES));
  p_res_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_res_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> done_val && !err_timeout && !err_resp);
  p_timeout_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> n_polls == MAX_POLLS);
  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_resp) |-> !busy && !awvalid && !arvalid);
endmodule

bind lite_poll_seq lps_checker #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MAX_POLLS(MAX_POLLS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
  .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
  .wdata(wdata), .wvalid(wvalid), .wready(wready), .bready(bready),
  .araddr(araddr), .arvalid(arvalid), .arready(arready), .rready(rready),
  .res_valid(res_valid), .done_val(done_val),
  .err_timeout(err_timeout), .err_resp(err_resp)
);

// File: tb/lite_poll_seq_tb_top.sv
module lite_poll_seq_tb_top;
  localparam logic [31:0] BASE = 32'h0001_2000;
  localparam int LAT  = 4;
  localparam int GAP  = 4;
  localparam int MAXP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [31:0] op_x = '0, op_a = '0, op_b = '0;
  logic [31:0] awaddr, wdata, araddr, res_data;
  logic [3:0]  wstrb;
  logic awvalid, wvalid, bready, arvalid, rready;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic busy, res_valid, done_val, err_timeout, err_resp;

  always #5 clk = ~clk;

  lite_poll_seq #(.ADDR_W(32), .BASE_ADDR(BASE), .LATENCY(LAT),
                  .POLL_GAP(GAP), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .op_x(op_x), .op_a(op_a), .op_b(op_b),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .busy(busy), .res_valid(res_valid), .res_data(res_data), .done_val(done_val),
    .err_timeout(err_timeout), .err_resp(err_resp)
  );

  // Slave configuration, driven from the test process only
  int stall = 0;
  int done_target = -1;
  int werr_at = -1;
  int rerr_at = -1;
  logic [31:0] result_val = '0;

  // Slave state and transaction log
  int cyc = 0;
  int widx = 0, ridx = 0, dcount = 0, res_cnt = 0;
  int aw_c = 0, w_c = 0, ar_c = 0;
  logic have_aw = 0, have_w = 0, have_ar = 0, ar_marked = 0;
  logic [31:0] aw_q = '0, w_q = '0, ar_q = '0;
  logic [3:0] strb_q = '0;
  logic [31:0] wl_addr [256];
  logic [31:0] wl_data [256];
  logic [3:0]  wl_strb [256];
  int          wl_cyc  [256];
  logic [31:0] rl_addr [256];
  int          rl_start[256];
  int          rl_end  [256];
  logic [31:0] res_last = '0;

  initial begin
    awready = 0; wready = 0; bvalid = 0; bresp = 0;
    arready = 0; rvalid = 0; rresp = 0; rdata = 0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (res_valid) begin
      res_cnt  <= res_cnt + 1;
      res_last <= res_data;
    end
    if (rst_n) begin
      // write side
      if (bvalid && bready) begin
        bvalid <= 0; have_aw <= 0; have_w <= 0; aw_c <= 0; w_c <= 0;
        wl_addr[widx] <= aw_q; wl_data[widx] <= w_q; wl_strb[widx] <= strb_q;
        wl_cyc[widx] <= cyc; widx <= widx + 1;
      end else if (have_aw && have_w && !bvalid) begin
        bvalid <= 1;
        bresp  <= (widx == werr_at) ? 2'b10 : 2'b00;
      end
      if (awvalid && awready) begin
        awready <= 0; have_aw <= 1; aw_q <= awaddr;
      end else if (awvalid && !have_aw) begin
        if (aw_c >= stall) awready <= 1; else aw_c <= aw_c + 1;
      end
      if (wvalid && wready) begin
        wready <= 0; have_w <= 1; w_q <= wdata; strb_q <= wstrb;
      end else if (wvalid && !have_w) begin
        if (w_c >= stall) wready <= 1; else w_c <= w_c + 1;
      end
      // read side
      if (arvalid && !ar_marked) begin
        rl_start[ridx] <= cyc; ar_marked <= 1;
      end
      if (rvalid && rready) begin
        rvalid <= 0; have_ar <= 0; ar_c <= 0; ar_marked <= 0;
        rl_addr[ridx] <= ar_q; rl_end[ridx] <= cyc; ridx <= ridx + 1;
        if (ar_q == BASE + 32'h04) dcount <= dcount + 1;
      end else if (have_ar && !rvalid) begin
        rvalid <= 1;
        rresp  <= (ridx == rerr_at) ? 2'b10 : 2'b00;
        if (ar_q == BASE + 32'h04)
          rdata <= (done_target >= 0 && dcount + 1 >= done_target) ? 32'h1 : 32'h0;
        else
          rdata <= result_val;
      end
      if (arvalid && arready) begin
        arready <= 0; have_ar <= 1; ar_q <= araddr;
      end else if (arvalid && !have_ar) begin
        if (ar_c >= stall) arready <= 1; else ar_c <= ar_c + 1;
      end
    end
  end

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  int w0, r0, res0;

  task automatic launch(input logic [31:0] x, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_x = x; op_a = a; op_b = b;
    w0 = widx; r0 = ridx; res0 = res_cnt;
    go = 1;
    @(negedge clk);
    go = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_writes(input logic [31:0] x, input logic [31:0] a,
                              input logic [31:0] b);
    check(wl_addr[w0] == BASE + 32'h08 && wl_data[w0] == x, "R1", "x write",
          wl_data[w0], x);
    check(wl_addr[w0+1] == BASE + 32'h0C && wl_data[w0+1] == a, "R1", "a write",
          wl_data[w0+1], a);
    check(wl_addr[w0+2] == BASE + 32'h10 && wl_data[w0+2] == b, "R1", "b write",
          wl_data[w0+2], b);
    check(wl_addr[w0+3] == BASE && wl_data[w0+3] == 1, "R1", "start write addr",
          wl_addr[w0+3], BASE);
    check(wl_strb[w0] == 4'hF && wl_strb[w0+3] == 4'hF, "R1", "strobes", wl_strb[w0], 15);
  endtask

  task automatic t_reset();
    check(!awvalid && !wvalid && !bready && !arvalid && !rready, "R10", "bus idle in reset",
          {awvalid, wvalid, bready, arvalid, rready}, 0);
    check(!busy && !res_valid && !err_timeout && !err_resp, "R10", "status in reset",
          {busy, res_valid, err_timeout, err_resp}, 0);
  endtask

  task automatic t_normal();
    stall = 0; done_target = dcount + 3; result_val = 32'h0000_000B;
    launch(32'd5, 32'd3, 32'hFFFF_FFFC);
    check(!err_timeout && !err_resp && busy, "R9", "errors cleared on go",
          {err_timeout, err_resp}, 0);
    wait_idle();
    check_writes(32'd5, 32'd3, 32'hFFFF_FFFC);
    check(widx - w0 == 4, "R2", "write count", widx - w0, 4);
    check(ridx - r0 == 4, "R6", "read count", ridx - r0, 4);
    check(rl_start[r0] - wl_cyc[w0+3] == LAT + 1, "R4", "initial latency",
          rl_start[r0] - wl_cyc[w0+3], LAT + 1);
    check(rl_start[r0+1] - rl_end[r0] == GAP + 1, "R5", "poll gap 1",
          rl_start[r0+1] - rl_end[r0], GAP + 1);
    check(rl_start[r0+2] - rl_end[r0+1] == GAP + 1, "R5", "poll gap 2",
          rl_start[r0+2] - rl_end[r0+1], GAP + 1);
    check(rl_addr[r0+3] == BASE + 32'h14, "R6", "result address", rl_addr[r0+3], BASE + 32'h14);
    check(rl_start[r0+3] - rl_end[r0+2] == 1, "R6", "result read immediate",
          rl_start[r0+3] - rl_end[r0+2], 1);
    check(rl_start[r0] > wl_cyc[w0+3], "R2", "read after last B", rl_start[r0], wl_cyc[w0+3]);
    check(res_cnt - res0 == 1, "R6", "one result pulse", res_cnt - res0, 1);
    check(res_last == 32'h0000_000B && done_val, "R6", "result value", res_last, 32'hB);
  endtask

  task automatic t_stall();
    stall = 2; done_target = dcount + 1; result_val = 32'hCAFE_0042;
    launch(32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
    wait_idle();
    check_writes(32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
    check(ridx - r0 == 2, "R6", "stalled read count", ridx - r0, 2);
    check(res_last == 32'hCAFE_0042 && res_cnt - res0 == 1, "R3", "result under stall",
          res_last, 32'hCAFE_0042);
    check(rl_start[r0] - wl_cyc[w0+3] == LAT + 1, "R4", "latency under stall",
          rl_start[r0] - wl_cyc[w0+3], LAT + 1);
    stall = 0;
  endtask

  task automatic t_timeout();
    done_target = -1;
    launch(32'd1, 32'd2, 32'd3);
    wait_idle();
    check(ridx - r0 == MAXP, "R7", "poll count", ridx - r0, MAXP);
    check(rl_addr[ridx-1] == BASE + 32'h04, "R7", "no result read", rl_addr[ridx-1], BASE + 4);
    check(err_timeout && !done_val && !err_resp, "R7", "timeout flag",
          {err_timeout, done_val, err_resp}, 4);
    check(res_cnt == res0, "R7", "no result pulse", res_cnt - res0, 0);
  endtask

  task automatic t_go_busy();
    done_target = dcount + 5; result_val = 32'h0000_0777;
    launch(32'hA, 32'hB, 32'hC);
    repeat (12) @(negedge clk);
    op_x = 32'hDEAD; op_a = 32'hBEEF; op_b = 32'hF00D;
    go = 1;
    @(negedge clk);
    go = 0;
    wait_idle();
    check(widx - w0 == 4, "R9", "no extra writes", widx - w0, 4);
    check_writes(32'hA, 32'hB, 32'hC);
    check(res_cnt - res0 == 1 && res_last == 32'h777, "R9", "single result", res_last, 32'h777);
    check(!err_timeout, "R9", "timeout flag cleared", err_timeout, 0);
  endtask

  task automatic t_wr_err();
    werr_at = widx + 1; done_target = dcount + 1;
    launch(32'h5, 32'h6, 32'h7);
    wait_idle();
    check(widx - w0 == 2, "R8", "writes stop at error", widx - w0, 2);
    check(ridx == r0, "R8", "no reads after error", ridx - r0, 0);
    check(err_resp && !busy && res_cnt == res0, "R8", "write error flag", err_resp, 1);
    werr_at = -1;
  endtask

  task automatic t_rd_err();
    rerr_at = ridx; done_target = dcount + 1;
    launch(32'h8, 32'h9, 32'hA);
    wait_idle();
    check(ridx - r0 == 1, "R8", "reads stop at error", ridx - r0, 1);
    check(err_resp && !busy && res_cnt == res0, "R8", "read error flag", err_resp, 1);
    rerr_at = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_normal();
    t_stall();
    t_timeout();
    t_go_busy();
    t_wr_err();
    t_rd_err();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule